// File: doc/BRIEF.md
# Partitioned Slave-Side Byte Memory

This block is a byte-wide local memory that two masters share: an on-chip CPU port and the slave side of an external serial bus (SPI or I2C shift logic sits outside and presents plain request/address/data signals). Three boundary inputs split the address space into four consecutive regions: a shared region from address zero, a region the external bus may only read, a FIFO region, and a region private to the CPU. Each boundary is given in 8-byte units, so the byte offset is the unit value shifted left by three.

The CPU may read and write any byte. It also feeds the FIFO region through a push port that keeps write and read pointers and a byte count. The external bus reaches the FIFO only by reading one reserved address, which pops the oldest byte. Five sticky interrupt flags report a count that falls below a threshold, push overflow, pop underflow, bus reads of forbidden regions, and bus writes outside the shared region. An enable mask selects which flags drive the interrupt line.

Top module: `plram_part`

## Requirements
- R1: The configuration is valid only when ro_base <= fifo_base <= ram_base, ro_base and fifo_base are at most 15 and ram_base is at most 32. Otherwise cfg_err is high, every bus access and every push has no effect, and a bus read returns 0x00.
- R2: With byte bounds B = base*8, an address a is in the shared region when a < B(ro), read-only when B(ro) <= a < B(fifo), FIFO when B(fifo) <= a < B(ram), and CPU-private otherwise.
- R3: A CPU write stores cpu_wdata at any address. A CPU read returns the byte on cpu_rdata in the cycle after the request.
- R4: A bus read of a shared or read-only address (other than 0x7F) returns the stored byte on bus_rdata in the cycle after the request.
- R5: A bus write is stored only in the shared region. A bus write anywhere else is dropped and sets flag bit 4 (write violation).
- R6: A bus read of a FIFO or CPU-private address other than 0x7F returns 0x00 and sets flag bit 3 (read error).
- R7: A bus read of address 0x7F pops the oldest FIFO byte; pointers wrap inside the FIFO region and fifo_count tracks the bytes held.
- R8: A push stores cpu_push_data at fifo byte base plus the write pointer and raises fifo_count. A push while the FIFO holds (ram_base-fifo_base)*8 bytes is dropped and sets flag bit 1 (overflow).
- R9: A pop while the FIFO is empty returns 0xFF and sets flag bit 2 (underflow).
- R10: Flag bit 0 is set when fifo_count goes from at least cfg_thresh to below it.
- R11: Flags reset to zero, stay set until a 1 is written to the matching irq_clr bit, a new event in the same cycle wins over a clear, and irq is high when any flag with its irq_en bit is set.
- R12: When the CPU and the bus write the same byte in one cycle, the CPU value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ro_base | input | 6 | Start of the read-only region in 8-byte units |
| cfg_fifo_base | input | 6 | Start of the FIFO region in 8-byte units |
| cfg_ram_base | input | 6 | Start of the CPU-private region in 8-byte units |
| cfg_thresh | input | 9 | FIFO count threshold |
| cfg_err | output | 1 | Boundary configuration is invalid |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the request |
| cpu_push | input | 1 | Push one byte into the FIFO |
| cpu_push_data | input | 8 | Byte to push |
| bus_req | input | 1 | External bus access request |
| bus_we | input | 1 | External bus access is a write |
| bus_addr | input | 8 | External bus byte address |
| bus_wdata | input | 8 | External bus write data |
| bus_rdata | output | 8 | External bus read data, one cycle after the request |
| fifo_count | output | 9 | Bytes held in the FIFO |
| irq_en | input | 5 | Interrupt enable mask |
| irq_clr | input | 5 | Write-one-to-clear strobes for the flags |
| irq_flags | output | 5 | Sticky flags: 0 threshold, 1 overflow, 2 underflow, 3 read error, 4 write violation |
| irq | output | 1 | Interrupt line |

## Verification
The bench sweeps the boundary inputs across and just past their legal limits, so a design that compared against the wrong maximum or accepted a reversed order would show a wrong cfg_err or let bus traffic through. It reads and writes every address from both sides under one configuration; an off-by-one region decode would leak a byte at a region edge or flag a legal access. The FIFO is filled past capacity, drained past empty and cycled twice around its region, catching a pointer that fails to wrap, a count that moves on a dropped push, and a threshold flag that fires on the wrong pop. A same-cycle CPU and bus write, a same-cycle event and clear, and a FIFO that ends exactly at the reserved address cover the priority rules.

// File: rtl/plram_pkg.sv
package plram_pkg;

   typedef enum logic [1:0] {
      RG_SHARED  = 2'd0,
      RG_RDONLY  = 2'd1,
      RG_QUEUE   = 2'd2,
      RG_PRIVATE = 2'd3
   } region_e;

   localparam int FL_THR  = 0;
   localparam int FL_OVF  = 1;
   localparam int FL_UDF  = 2;
   localparam int FL_RDE  = 3;
   localparam int FL_WVIO = 4;
   localparam int FL_N    = 5;

endpackage

// File: rtl/plram_region_dec.sv
module plram_region_dec
   import plram_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int UNIT_LG = 3
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [ADDR_W-UNIT_LG:0] ro_base,
   input  logic [ADDR_W-UNIT_LG:0] fifo_base,
   input  logic [ADDR_W-UNIT_LG:0] ram_base,
   output region_e                 region
);
   localparam int BW = ADDR_W + 1;

   logic [BW-1:0] a_x, ro_x, ff_x, rm_x;

   assign a_x  = {1'b0, addr};
   assign ro_x = {ro_base,   {UNIT_LG{1'b0}}};
   assign ff_x = {fifo_base, {UNIT_LG{1'b0}}};
   assign rm_x = {ram_base,  {UNIT_LG{1'b0}}};

   always_comb begin
      if (a_x < ro_x)      region = RG_SHARED;
      else if (a_x < ff_x) region = RG_RDONLY;
      else if (a_x < rm_x) region = RG_QUEUE;
      else                 region = RG_PRIVATE;
   end

endmodule

// File: rtl/plram_fifo_ctl.sv
module plram_fifo_ctl #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W:0]   cap,
   input  logic [PTR_W:0]   thresh,
   input  logic             push_req,
   input  logic             pop_req,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W:0]   count,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             ovf_evt,
   output logic             udf_evt,
   output logic             thr_evt
);
   localparam logic [PTR_W:0] ONE_C = 1;

   logic [PTR_W:0]   count_d;
   logic [PTR_W:0]   wr_inc, rd_inc;
   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic             has_room, has_data;

   assign has_room = (count < cap);
   assign has_data = (count != '0);
   assign push_ok  = push_req & has_room;
   assign ovf_evt  = push_req & ~has_room;
   assign pop_ok   = pop_req & has_data;
   assign udf_evt  = pop_req & ~has_data;

   assign wr_inc = {1'b0, wr_ptr} + ONE_C;
   assign rd_inc = {1'b0, rd_ptr} + ONE_C;
   assign wr_nxt = (wr_inc >= cap) ? '0 : wr_inc[PTR_W-1:0];
   assign rd_nxt = (rd_inc >= cap) ? '0 : rd_inc[PTR_W-1:0];

   always_comb begin
      count_d = count;
      if (push_ok && !pop_ok)      count_d = count + ONE_C;
      else if (pop_ok && !push_ok) count_d = count - ONE_C;
   end

   assign thr_evt = (count >= thresh) && (count_d < thresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         count <= count_d;
      end
   end

endmodule

// File: rtl/plram_irq.sv
module plram_irq #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | set_evt;
   end

   assign irq = |(flags & en);

endmodule

// File: rtl/plram_part.sv
module plram_part
   import plram_pkg::*;
#(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter int                UNIT_LG    = 3,
   parameter logic [ADDR_W-1:0] POP_ADDR   = 'h7F,
   parameter logic [DATA_W-1:0] EMPTY_FILL = '1,
   parameter bit                CPU_PRIO   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-UNIT_LG:0] cfg_ro_base,
   input  logic [ADDR_W-UNIT_LG:0] cfg_fifo_base,
   input  logic [ADDR_W-UNIT_LG:0] cfg_ram_base,
   input  logic [ADDR_W:0]         cfg_thresh,
   output logic                    cfg_err,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic [DATA_W-1:0]       cpu_rdata,
   input  logic                    cpu_push,
   input  logic [DATA_W-1:0]       cpu_push_data,
   input  logic                    bus_req,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [ADDR_W:0]         fifo_count,
   input  logic [FL_N-1:0]         irq_en,
   input  logic [FL_N-1:0]         irq_clr,
   output logic [FL_N-1:0]         irq_flags,
   output logic                    irq
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int BND_W = ADDR_W - UNIT_LG + 1;
   localparam int CNT_W = ADDR_W + 1;
   localparam logic [BND_W-1:0] SEG_MAX = BND_W'(POP_ADDR >> UNIT_LG);
   localparam logic [BND_W-1:0] RAM_MAX = BND_W'(DEPTH >> UNIT_LG);

   if (UNIT_LG < 1 || UNIT_LG >= ADDR_W) begin : g_bad_unit
      $error("plram_part: UNIT_LG must lie in 1..ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("plram_part: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   region_e           bus_region;
   logic              bus_ok, bus_pop, bus_wr_ok, viol_evt, rde_evt;
   logic              cpu_wr, push_req;
   logic [CNT_W-1:0]  cap, fifo_byte, push_sum, pop_sum;
   logic [ADDR_W-1:0] wr_ptr, rd_ptr, push_addr, pop_addr;
   logic              push_ok, pop_ok, ovf_evt, udf_evt, thr_evt;
   logic [FL_N-1:0]   set_evt;
   logic [DATA_W-1:0] bus_rd_d, cpu_rdata_q, bus_rdata_q;

   // boundary legality
   assign cfg_err = (cfg_ro_base > cfg_fifo_base) | (cfg_fifo_base > cfg_ram_base) |
                    (cfg_ro_base > SEG_MAX) | (cfg_fifo_base > SEG_MAX) |
                    (cfg_ram_base > RAM_MAX);

   plram_region_dec #(.ADDR_W(ADDR_W), .UNIT_LG(UNIT_LG)) u_bus_dec (
      .addr      (bus_addr),
      .ro_base   (cfg_ro_base),
      .fifo_base (cfg_fifo_base),
      .ram_base  (cfg_ram_base),
      .region    (bus_region)
   );

   assign bus_ok    = bus_req & ~cfg_err;
   assign bus_pop   = bus_ok & ~bus_we & (bus_addr == POP_ADDR);
   assign bus_wr_ok = bus_ok & bus_we & (bus_region == RG_SHARED);
   assign viol_evt  = bus_ok & bus_we & (bus_region != RG_SHARED);
   assign rde_evt   = bus_ok & ~bus_we & ~bus_pop &
                      ((bus_region == RG_QUEUE) | (bus_region == RG_PRIVATE));
   assign cpu_wr    = cpu_req & cpu_we;
   assign push_req  = cpu_push & ~cfg_err;

   // FIFO geometry
   assign cap       = cfg_err ? '0 : {(cfg_ram_base - cfg_fifo_base), {UNIT_LG{1'b0}}};
   assign fifo_byte = {cfg_fifo_base, {UNIT_LG{1'b0}}};
   assign push_sum  = fifo_byte + {1'b0, wr_ptr};
   assign pop_sum   = fifo_byte + {1'b0, rd_ptr};
   assign push_addr = push_sum[ADDR_W-1:0];
   assign pop_addr  = pop_sum[ADDR_W-1:0];

   plram_fifo_ctl #(.PTR_W(ADDR_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .thresh   (cfg_thresh),
      .push_req (push_req),
      .pop_req  (bus_pop),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .count    (fifo_count),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .ovf_evt  (ovf_evt),
      .udf_evt  (udf_evt),
      .thr_evt  (thr_evt)
   );

   // storage: write order picks the winner of a same-byte collision
   if (CPU_PRIO) begin : g_cpu_last
      always_ff @(posedge clk) begin
         if (bus_wr_ok) mem[bus_addr]  <= bus_wdata;
         if (push_ok)   mem[push_addr] <= cpu_push_data;
         if (cpu_wr)    mem[cpu_addr]  <= cpu_wdata;
      end
   end else begin : g_bus_last
      always_ff @(posedge clk) begin
         if (cpu_wr)    mem[cpu_addr]  <= cpu_wdata;
         if (push_ok)   mem[push_addr] <= cpu_push_data;
         if (bus_wr_ok) mem[bus_addr]  <= bus_wdata;
      end
   end

   always_comb begin
      bus_rd_d = '0;
      if (bus_ok) begin
         if (bus_pop)
            bus_rd_d = pop_ok ? mem[pop_addr] : EMPTY_FILL;
         else if ((bus_region == RG_SHARED) || (bus_region == RG_RDONLY))
            bus_rd_d = mem[bus_addr];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rdata_q <= '0;
         bus_rdata_q <= '0;
      end else begin
         if (cpu_req && !cpu_we) cpu_rdata_q <= mem[cpu_addr];
         if (bus_req && !bus_we) bus_rdata_q <= bus_rd_d;
      end
   end

   assign cpu_rdata = cpu_rdata_q;
   assign bus_rdata = bus_rdata_q;

   always_comb begin
      set_evt          = '0;
      set_evt[FL_THR]  = thr_evt;
      set_evt[FL_OVF]  = ovf_evt;
      set_evt[FL_UDF]  = udf_evt;
      set_evt[FL_RDE]  = rde_evt;
      set_evt[FL_WVIO] = viol_evt;
   end

   plram_irq #(.N(FL_N)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt),
      .clr     (irq_clr),
      .en      (irq_en),
      .flags   (irq_flags),
      .irq     (irq)
   );

endmodule

// File: rtl/plram_part_chk.sv
module plram_part_chk
   import plram_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter int                UNIT_LG  = 3,
   parameter logic [ADDR_W-1:0] POP_ADDR = 'h7F
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-UNIT_LG:0] cfg_ro_base,
   input logic [ADDR_W-UNIT_LG:0] cfg_fifo_base,
   input logic [ADDR_W-UNIT_LG:0] cfg_ram_base,
   input logic                    cfg_err,
   input logic                    bus_req,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [DATA_W-1:0]       bus_rdata,
   input logic [ADDR_W:0]         fifo_count,
   input logic [FL_N-1:0]         irq_clr,
   input logic [FL_N-1:0]         irq_flags
);
   localparam logic [ADDR_W:0] ONE_C = 1;

   logic [ADDR_W:0] a_x, ro_x, ff_x, room_x;

   assign a_x    = {1'b0, bus_addr};
   assign ro_x   = {cfg_ro_base,   {UNIT_LG{1'b0}}};
   assign ff_x   = {cfg_fifo_base, {UNIT_LG{1'b0}}};
   assign room_x = {(cfg_ram_base - cfg_fifo_base), {UNIT_LG{1'b0}}};

   AST_CFG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && bus_req && !bus_we) |=> (bus_rdata == '0)); // R1
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> (fifo_count == $past(fifo_count))); // R1
   AST_WR_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && !cfg_err && (a_x >= ro_x)) |=> irq_flags[FL_WVIO]); // R5
   AST_RD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && !cfg_err && (bus_addr != POP_ADDR) && (a_x >= ff_x))
      |=> (irq_flags[FL_RDE] && (bus_rdata == '0))); // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fifo_count == $past(fifo_count)) ||
                (fifo_count == $past(fifo_count) + ONE_C) ||
                (fifo_count + ONE_C == $past(fifo_count)))); // R7
   AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_err |-> (fifo_count <= room_x)); // R8
   AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && !cfg_err && (bus_addr == POP_ADDR) && (fifo_count == '0))
      |=> ((bus_rdata == '1) && irq_flags[FL_UDF])); // R9
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(irq_flags) & ~$past(irq_clr) & ~irq_flags) == '0)); // R11

endmodule

bind plram_part plram_part_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .UNIT_LG  (UNIT_LG),
   .POP_ADDR (POP_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_ro_base   (cfg_ro_base),
   .cfg_fifo_base (cfg_fifo_base),
   .cfg_ram_base  (cfg_ram_base),
   .cfg_err       (cfg_err),
   .bus_req       (bus_req),
   .bus_we        (bus_we),
   .bus_addr      (bus_addr),
   .bus_rdata     (bus_rdata),
   .fifo_count    (fifo_count),
   .irq_clr       (irq_clr),
   .irq_flags     (irq_flags)
);

// File: tb/plram_part_bench.sv
`timescale 1ns/1ps
module plram_part_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cfg_ro_base = 6'd4, cfg_fifo_base = 6'd8, cfg_ram_base = 6'd10;
   logic [8:0] cfg_thresh = 9'd4;
   logic       cfg_err;
   logic       cpu_req = 0, cpu_we = 0, cpu_push = 0;
   logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata, cpu_push_data = 0;
   logic       bus_req = 0, bus_we = 0;
   logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
   logic [8:0] fifo_count;
   logic [4:0] irq_en = 0, irq_clr = 0, irq_flags;
   logic       irq;

   int nvec = 0;
   int nerr = 0;
   logic [7:0] exp_mem [256];
   logic [7:0] rd;

   always #2.5 clk = ~clk;

   plram_part u_plram_part (
      .clk(clk), .rst_n(rst_n),
      .cfg_ro_base(cfg_ro_base), .cfg_fifo_base(cfg_fifo_base),
      .cfg_ram_base(cfg_ram_base), .cfg_thresh(cfg_thresh), .cfg_err(cfg_err),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_push(cpu_push), .cpu_push_data(cpu_push_data),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fifo_count(fifo_count),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq_flags(irq_flags), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
      cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 0; cpu_we = 0;
   endtask

   task automatic cpu_rd(input logic [7:0] a, output logic [7:0] d);
      cpu_req = 1; cpu_we = 0; cpu_addr = a;
      @(negedge clk);
      cpu_req = 0;
      d = cpu_rdata;
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 0; bus_we = 0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
      bus_req = 1; bus_we = 0; bus_addr = a;
      @(negedge clk);
      bus_req = 0;
      d = bus_rdata;
   endtask

   task automatic push(input logic [7:0] d);
      cpu_push = 1; cpu_push_data = d;
      @(negedge clk);
      cpu_push = 0;
   endtask

   task automatic clr_all();
      irq_clr = 5'h1F;
      @(negedge clk);
      irq_clr = 0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R11, R7, R3, R4)
      chk("R11 flags after reset", irq_flags, 0);
      chk("R11 irq after reset", irq, 0);
      chk("R7 count after reset", fifo_count, 0);
      chk("R3 cpu_rdata after reset", cpu_rdata, 0);
      chk("R4 bus_rdata after reset", bus_rdata, 0);

      // R1: boundary legality sweep
      for (int ro = 0; ro < 18; ro++)
         for (int ff = 0; ff < 18; ff++)
            for (int k = 0; k < 6; k++) begin
               int rm;
               logic e;
               rm = (k == 0) ? 0 : (k == 1) ? 8 : (k == 2) ? 15 : (k == 3) ? 16 : (k == 4) ? 32 : 33;
               cfg_ro_base = 6'(ro); cfg_fifo_base = 6'(ff); cfg_ram_base = 6'(rm);
               #0.1;
               e = (ro > ff) || (ff > rm) || (ro > 15) || (ff > 15) || (rm > 32);
               chk("R1 cfg_err", cfg_err, e);
            end
      cfg_ro_base = 6'd4; cfg_fifo_base = 6'd8; cfg_ram_base = 6'd10;
      @(negedge clk);
      chk("R1 main config valid", cfg_err, 0);

      // R3: CPU full access
      for (int a = 0; a < 256; a++) begin
         exp_mem[a] = 8'(a) ^ 8'h5A;
         cpu_wr(8'(a), exp_mem[a]);
      end
      for (int a = 0; a < 256; a++) begin
         cpu_rd(8'(a), rd);
         chk("R3 cpu read", rd, exp_mem[a]);
      end

      // R4/R2: bus reads of shared and read-only regions (0x00..0x3F)
      for (int a = 0; a < 64; a++) begin
         bus_rd(8'(a), rd);
         chk("R4 bus read", rd, exp_mem[a]);
      end
      chk("R6 no read error in legal regions", irq_flags, 0);

      // R6/R2: forbidden reads return zero
      for (int a = 64; a < 256; a++) begin
         if (a != 8'h7F) begin
            bus_rd(8'(a), rd);
            chk("R6 forbidden bus read", rd, 0);
         end
      end
      chk("R6 read error flag", irq_flags, 5'h08);
      clr_all();
      chk("R11 clear by write one", irq_flags, 0);

      // R5/R2: bus writes everywhere, only 0x00..0x1F stick
      for (int a = 0; a < 256; a++) begin
         bus_wr(8'(a), ~8'(a));
         if (a < 32) exp_mem[a] = ~8'(a);
      end
      chk("R5 write violation flag", irq_flags, 5'h10);
      chk("R7 drops leave count", fifo_count, 0);
      clr_all();
      for (int a = 0; a < 256; a++) begin
         cpu_rd(8'(a), rd);
         chk("R5 memory after bus writes", rd, exp_mem[a]);
      end

      // R12: same-cycle collision
      cpu_req = 1; cpu_we = 1; cpu_addr = 8'h05; cpu_wdata = 8'h11;
      bus_req = 1; bus_we = 1; bus_addr = 8'h05; bus_wdata = 8'h22;
      @(negedge clk);
      cpu_req = 0; cpu_we = 0; bus_req = 0; bus_we = 0;
      exp_mem[5] = 8'h11;
      cpu_rd(8'h05, rd);
      chk("R12 cpu wins collision", rd, 8'h11);

      // R8: fill FIFO (region 0x40..0x4F, 16 bytes), then overflow
      for (int i = 0; i < 16; i++) begin
         push(8'hA0 + 8'(i));
         chk("R8 count on push", fifo_count, i + 1);
      end
      chk("R10 no threshold flag while filling", irq_flags, 0);
      push(8'hEE);
      chk("R8 overflow flag", irq_flags, 5'h02);
      chk("R8 overflow leaves count", fifo_count, 16);
      cpu_rd(8'h40, rd);
      chk("R8 push lands at fifo base", rd, 8'hA0);
      cpu_rd(8'h4F, rd);
      chk("R8 push lands at region end", rd, 8'hAF);
      clr_all();

      // R7/R10: drain in order, threshold crosses on 13th pop
      for (int k = 0; k < 16; k++) begin
         bus_rd(8'h7F, rd);
         chk("R7 pop order", rd, 8'hA0 + 8'(k));
         chk("R7 count on pop", fifo_count, 15 - k);
         chk("R10 threshold flag", irq_flags[0], (15 - k) < 4);
      end

      // R9: underflow
      bus_rd(8'h7F, rd);
      chk("R9 empty pop data", rd, 8'hFF);
      chk("R9 underflow flag", irq_flags, 5'h05);
      chk("R9 count stays zero", fifo_count, 0);
      clr_all();

      // R7: wrap-around inside the region
      for (int r = 0; r < 2; r++) begin
         for (int i = 0; i < 10; i++) push(8'(8'h30 * (r + 1)) + 8'(i));
         for (int i = 0; i < 10; i++) begin
            bus_rd(8'h7F, rd);
            chk("R7 wrap pop", rd, 8'(8'h30 * (r + 1)) + 8'(i));
         end
      end
      chk("R7 count after wrap", fifo_count, 0);
      clr_all();

      // R11: mask and set-over-clear
      bus_wr(8'h30, 8'h00);
      #0.1 chk("R11 irq masked", irq, 0);
      irq_en = 5'h10;
      #0.1 chk("R11 irq enabled", irq, 1);
      irq_en = 5'h0F;
      #0.1 chk("R11 irq other mask", irq, 0);
      irq_clr = 5'h10;
      bus_wr(8'h30, 8'h00);
      irq_clr = 0;
      chk("R11 set wins over clear", irq_flags, 5'h10);
      clr_all();
      irq_en = 0;

      // R1: invalid configuration blocks the bus and pushes
      cfg_ro_base = 6'd9; cfg_fifo_base = 6'd8;
      @(negedge clk);
      chk("R1 cfg_err raised", cfg_err, 1);
      bus_wr(8'h02, 8'h77);
      bus_rd(8'h02, rd);
      chk("R1 blocked bus read", rd, 0);
      bus_rd(8'h7F, rd);
      chk("R1 blocked pop", rd, 0);
      push(8'h55);
      chk("R1 blocked push", fifo_count, 0);
      chk("R1 no flags while blocked", irq_flags, 0);
      cfg_ro_base = 6'd4;
      @(negedge clk);
      cpu_rd(8'h02, rd);
      chk("R1 blocked write dropped", rd, exp_mem[2]);

      // R7/R6/R2: FIFO region ending exactly at the reserved address
      cfg_ro_base = 6'd15; cfg_fifo_base = 6'd15; cfg_ram_base = 6'd16;
      @(negedge clk);
      chk("R1 top config valid", cfg_err, 0);
      push(8'h99);
      chk("R8 push in top region", fifo_count, 1);
      bus_rd(8'h7F, rd);
      chk("R7 reserved address pops", rd, 8'h99);
      chk("R7 count after pop", fifo_count, 0);
      chk("R7 pop raises no error", irq_flags[3], 0);
      bus_rd(8'h7E, rd);
      chk("R6 read of queue byte", rd, 0);
      chk("R6 read error in top region", irq_flags[3], 1);
      bus_rd(8'h77, rd);
      chk("R2 last shared byte", rd, exp_mem[8'h77]);

      finish_run();
   end

endmodule